// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block runs the processor side of the acknowledge handshake for an eight-input interrupt controller. Arbitration elsewhere hands it the winning level and a valid flag. The block raises the interrupt line while a request waits. It watches the active-low acknowledge strobe and counts two low pulses. On the first pulse it issues a one-cycle commit strobe, which the register logic uses to set the in-service bit and clear the request bit. On the second pulse it places the vector byte on the data bus.

In a cascaded system, a master marks which of its inputs carry a subordinate controller. When such an input is acknowledged, the master drives that input number on the 3-bit cascade lines for the whole sequence and keeps off the data bus. A subordinate compares the cascade lines with its own programmed identity. It commits and supplies the vector only when the two match. When automatic end-of-interrupt is enabled, the block emits an end-of-service strobe as the final pulse ends. A flag on that strobe asks for a priority rotation.

The acknowledge strobe is taken to be synchronous to `clk`. The configuration inputs are held steady while a sequence is in progress.

Top module: `intack_seq`

## Requirements
- R1: The cycle after the first acknowledge pulse falls, `commit_stb` is high for exactly one cycle and `commit_lvl` holds the winning level, provided `req_valid` was high when the pulse fell.
- R2: When no sequence is in progress, `int_o` follows `req_valid`. From the cycle after the first falling edge of the strobe until the sequence ends, `int_o` is low.
- R3: If `req_valid` is low when the first pulse falls, no commit strobe is issued and the vector carries level 7.
- R4: During the second pulse, `dout_en` is high and `dout` is `{vec_base[4:0], level[2:0]}`, with the base in bits 7..3 and the level in bits 2..0. At all other times `dout_en` is low and `dout` is zero.
- R5: When `auto_eoi` is 1 and a commit took place, `eoi_stb` pulses for one cycle right after the second pulse rises. `eoi_lvl` carries the committed level and `eoi_rot` equals `rot_aeoi`. When `auto_eoi` is 0, no `eoi_stb` occurs.
- R6: With `casc_en`=1, `is_master`=1 and `slave_map[level]`=1, `cas_oe` is high and `cas_o` equals the level from the cycle after the first pulse falls until the second pulse ends. `dout_en` stays low.
- R7: With `casc_en`=1, `is_master`=1 and `slave_map[level]`=0, `cas_oe` stays low and the master supplies the vector itself.
- R8: With `casc_en`=1 and `is_master`=0, the device commits, supplies the vector and may issue `eoi_stb` only if `cas_in` equals `my_id` when the first pulse falls. Otherwise it does none of these.
- R9: With `casc_en`=0, the device always supplies the vector and `cas_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inta_n | input | 1 | Acknowledge strobe, active low |
| req_valid | input | 1 | A winning request exists |
| req_level | input | 3 | Winning level |
| vec_base | input | 5 | Upper five bits of the vector |
| auto_eoi | input | 1 | Automatic end-of-service enable |
| rot_aeoi | input | 1 | Rotate on automatic end-of-service |
| casc_en | input | 1 | Cascaded system |
| is_master | input | 1 | Device role: 1 master, 0 subordinate |
| slave_map | input | 8 | Inputs that carry a subordinate (master role) |
| my_id | input | 3 | Own identity (subordinate role) |
| cas_in | input | 3 | Cascade lines as seen at the pins |
| int_o | output | 1 | Interrupt request to the processor |
| commit_stb | output | 1 | Set in-service / clear request strobe |
| commit_lvl | output | 3 | Level to commit |
| cas_o | output | 3 | Cascade identity driven by a master |
| cas_oe | output | 1 | Cascade drive enable |
| dout | output | 8 | Vector byte |
| dout_en | output | 1 | Data bus drive enable |
| eoi_stb | output | 1 | Automatic end-of-service strobe |
| eoi_lvl | output | 3 | Level to clear |
| eoi_rot | output | 1 | Rotate priorities on that clear |

## Verification
The embedded properties hold on every cycle for these rules: the commit strobe lasts a single cycle and never occurs without a prior valid request; the interrupt line drops right after the first strobe edge; the end-of-service strobe requires its mode; and only a master in a cascaded system drives the cascade lines. The exact vector values, level 7 after a vanished request, identity matching in the subordinate role, and cascade drive persisting across both pulses depend on whole pulse sequences. Only the bench's scenarios show those.

// File: rtl/intack_pkg.sv
package intack_pkg;

    localparam int LVL_W  = 3;
    localparam int N_IN   = 1 << LVL_W;
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - LVL_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_P1   = 2'd1,
        ST_GAP  = 2'd2,
        ST_P2   = 2'd3
    } ack_state_e;

    // routing decision taken at the first strobe edge
    typedef struct packed {
        logic casdrv;   // master drives the cascade identity
        logic supply;   // this device owns the data bus on pulse two
        logic allowed;  // this device may commit
    } route_t;

    // state frozen for the rest of the sequence
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             hit;
        logic             supply;
        logic             casdrv;
    } capture_t;

    function automatic logic [DATA_W-1:0] make_vector(
        input logic [BASE_W-1:0] base,
        input logic [LVL_W-1:0]  lvl
    );
        return {base, lvl};
    endfunction

endpackage

// File: rtl/ack_edge_det.sv
module ack_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end

    assign fall = prev_q & ~strobe_n;
    assign rise = ~prev_q & strobe_n;
endmodule

// File: rtl/ack_cascade.sv
module ack_cascade
    import intack_pkg::*;
(
    input  logic             casc_en,
    input  logic             is_master,
    input  logic [N_IN-1:0]  slave_map,
    input  logic [LVL_W-1:0] my_id,
    input  logic [LVL_W-1:0] cas_in,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    output route_t           route
);
    logic [N_IN-1:0] lvl_hot;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_hot
            assign lvl_hot[i] = (req_level == LVL_W'(i));
        end
    endgenerate

    logic slave_here;
    logic id_match;

    always_comb begin
        slave_here = casc_en && is_master && req_valid && (|(lvl_hot & slave_map));
        id_match   = (cas_in == my_id);
        route.casdrv  = slave_here;
        route.allowed = !(casc_en && !is_master) || id_match;
        if (!casc_en)       route.supply = 1'b1;
        else if (is_master) route.supply = !slave_here;
        else                route.supply = id_match;
    end
endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
    import intack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             rise,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             auto_eoi,
    input  logic             rot_aeoi,
    input  route_t           route,
    output ack_state_e       state,
    output capture_t         cap,
    output logic             commit_stb,
    output logic [LVL_W-1:0] commit_lvl,
    output logic             eoi_stb,
    output logic [LVL_W-1:0] eoi_lvl,
    output logic             eoi_rot
);
    logic hit_now;
    assign hit_now = req_valid && route.allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cap        <= '0;
            commit_stb <= 1'b0;
            commit_lvl <= '0;
            eoi_stb    <= 1'b0;
            eoi_lvl    <= '0;
            eoi_rot    <= 1'b0;
        end else begin
            commit_stb <= 1'b0;
            eoi_stb    <= 1'b0;
            unique case (state)
                ST_IDLE: if (fall) begin
                    state      <= ST_P1;
                    cap.lvl    <= req_valid ? req_level : {LVL_W{1'b1}};
                    cap.hit    <= hit_now;
                    cap.supply <= route.supply;
                    cap.casdrv <= route.casdrv;
                    commit_stb <= hit_now;
                    commit_lvl <= req_level;
                end
                ST_P1:  if (rise) state <= ST_GAP;
                ST_GAP: if (fall) state <= ST_P2;
                ST_P2:  if (rise) begin
                    state      <= ST_IDLE;
                    eoi_stb    <= auto_eoi && cap.hit;
                    eoi_lvl    <= cap.lvl;
                    eoi_rot    <= rot_aeoi;
                    cap.casdrv <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: commit is a single-cycle strobe
    a_r1_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit_stb |=> !commit_stb);

    // R3: no commit without a request present at the first edge
    a_r3_commit_needs_req: assert property (@(posedge clk) disable iff (rst)
        commit_stb |-> $past(req_valid));

    // R5: end-of-service strobe only in automatic mode
    a_r5_eoi_needs_mode: assert property (@(posedge clk) disable iff (rst)
        eoi_stb |-> $past(auto_eoi));
endmodule

// File: rtl/ack_vector.sv
module ack_vector
    import intack_pkg::*;
(
    input  ack_state_e        state,
    input  capture_t          cap,
    input  logic [BASE_W-1:0] vec_base,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [LVL_W-1:0]  cas_o,
    output logic              cas_oe
);
    always_comb begin
        dout_en = (state == ST_P2) && cap.supply;
        dout    = dout_en ? make_vector(vec_base, cap.lvl) : '0;
        cas_oe  = (state != ST_IDLE) && cap.casdrv;
        cas_o   = cas_oe ? cap.lvl : '0;
    end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inta_n,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              auto_eoi,
    input  logic              rot_aeoi,
    input  logic              casc_en,
    input  logic              is_master,
    input  logic [N_IN-1:0]   slave_map,
    input  logic [LVL_W-1:0]  my_id,
    input  logic [LVL_W-1:0]  cas_in,
    output logic              int_o,
    output logic              commit_stb,
    output logic [LVL_W-1:0]  commit_lvl,
    output logic [LVL_W-1:0]  cas_o,
    output logic              cas_oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              eoi_stb,
    output logic [LVL_W-1:0]  eoi_lvl,
    output logic              eoi_rot
);
    logic       fall, rise;
    route_t     route;
    ack_state_e state;
    capture_t   cap;

    ack_edge_det u_edge (
        .clk(clk), .rst(rst), .strobe_n(inta_n), .fall(fall), .rise(rise)
    );

    ack_cascade u_casc (
        .casc_en(casc_en), .is_master(is_master), .slave_map(slave_map),
        .my_id(my_id), .cas_in(cas_in), .req_valid(req_valid),
        .req_level(req_level), .route(route)
    );

    ack_fsm u_fsm (
        .clk(clk), .rst(rst), .fall(fall), .rise(rise),
        .req_valid(req_valid), .req_level(req_level),
        .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .route(route),
        .state(state), .cap(cap),
        .commit_stb(commit_stb), .commit_lvl(commit_lvl),
        .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl), .eoi_rot(eoi_rot)
    );

    ack_vector u_vec (
        .state(state), .cap(cap), .vec_base(vec_base),
        .dout(dout), .dout_en(dout_en), .cas_o(cas_o), .cas_oe(cas_oe)
    );

    assign int_o = req_valid && (state == ST_IDLE);

    // R2: interrupt line drops right after the first strobe edge
    a_r2_int_drops: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !inta_n && $past(inta_n)) |=> !int_o);

    // R6: only a master in a cascaded system drives the cascade lines
    a_r6_cas_master_only: assert property (@(posedge clk) disable iff (rst)
        cas_oe |-> (casc_en && is_master));
endmodule

// File: tb/sim_intack_seq.sv
module sim_intack_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, inta_n = 1'b1, req_valid = 1'b0;
    logic [2:0] req_level = '0, my_id = '0, cas_in = '0;
    logic [4:0] vec_base = '0;
    logic       auto_eoi = 1'b0, rot_aeoi = 1'b0, casc_en = 1'b0, is_master = 1'b1;
    logic [7:0] slave_map = '0;
    logic       int_o, commit_stb, cas_oe, dout_en, eoi_stb, eoi_rot;
    logic [2:0] commit_lvl, cas_o, eoi_lvl;
    logic [7:0] dout;

    intack_seq u0 (.*);

    int n_chk = 0, n_bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // observations from one acknowledge sequence
    logic o_int_pre, o_commit, o_int_p1, o_cas_oe1, o_den, o_cas_oe2, o_eoi, o_erot, o_cas_oe_end, o_den_end;
    logic [2:0] o_clvl, o_cas1, o_elvl;
    logic [7:0] o_dout;

    task automatic run_ack();
        @(negedge clk); o_int_pre = int_o; inta_n = 1'b0;
        @(negedge clk); o_commit = commit_stb; o_clvl = commit_lvl; o_int_p1 = int_o;
                        o_cas_oe1 = cas_oe; o_cas1 = cas_o;
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); inta_n = 1'b0;
        @(negedge clk); o_den = dout_en; o_dout = dout; o_cas_oe2 = cas_oe;
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); o_eoi = eoi_stb; o_elvl = eoi_lvl; o_erot = eoi_rot;
                        o_cas_oe_end = cas_oe; o_den_end = dout_en;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // {rv, lvl[2:0], base[4:0], aeoi, rot, exp_vec[7:0], exp_commit, exp_eoi}
    localparam logic [20:0] VECS [6] = '{
        {1'b1, 3'd0, 5'h01, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0},
        {1'b1, 3'd5, 5'h08, 1'b1, 1'b0, 8'h45, 1'b1, 1'b1},
        {1'b1, 3'd7, 5'h1F, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1},
        {1'b0, 3'd3, 5'h08, 1'b1, 1'b0, 8'h47, 1'b0, 1'b0},
        {1'b1, 3'd3, 5'h10, 1'b0, 1'b1, 8'h83, 1'b1, 1'b0},
        {1'b1, 3'd2, 5'h00, 1'b1, 1'b1, 8'h02, 1'b1, 1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R2 int idle no req", int_o, 0);
        check("R4 dout_en reset", dout_en, 0);
        check("R4 dout reset", dout, 0);
        check("R9 cas_oe reset", cas_oe, 0);
        check("R1 commit reset", commit_stb, 0);
        req_valid = 1'b1; @(negedge clk);
        check("R2 int follows req", int_o, 1);
        req_valid = 1'b0;

        // single-device table (R9)
        for (int k = 0; k < 6; k++) begin
            logic [20:0] v;
            v = VECS[k];
            req_valid = v[20]; req_level = v[19:17]; vec_base = v[16:12];
            auto_eoi = v[11]; rot_aeoi = v[10];
            run_ack();
            check("R2 int before ack", o_int_pre, v[20]);
            check("R1 R3 commit strobe", o_commit, v[1]);
            if (v[1]) check("R1 commit level", o_clvl, v[19:17]);
            check("R2 int low after pulse", o_int_p1, 0);
            check("R4 R9 dout_en pulse two", o_den, 1);
            check("R3 R4 vector byte", o_dout, v[9:2]);
            check("R5 eoi strobe", o_eoi, v[0]);
            if (v[0]) begin
                check("R5 eoi level", o_elvl, v[19:17]);
                check("R5 eoi rotate", o_erot, v[10]);
            end
            check("R9 no cascade drive", o_cas_oe1, 0);
            check("R4 dout_en after seq", o_den_end, 0);
        end

        // master with subordinate on input 2 (R6)
        casc_en = 1'b1; is_master = 1'b1; slave_map = 8'h04; vec_base = 5'h08;
        auto_eoi = 1'b1; rot_aeoi = 1'b0;
        req_valid = 1'b1; req_level = 3'd2;
        run_ack();
        check("R6 cas_oe pulse one", o_cas_oe1, 1);
        check("R6 cas id", o_cas1, 2);
        check("R6 cas_oe pulse two", o_cas_oe2, 1);
        check("R6 master off bus", o_den, 0);
        check("R6 cas released", o_cas_oe_end, 0);
        check("R6 R1 master commits", o_commit, 1);

        // master, input without subordinate (R7)
        req_valid = 1'b1; req_level = 3'd5;
        run_ack();
        check("R7 no cas drive", o_cas_oe1, 0);
        check("R7 master supplies", o_den, 1);
        check("R7 vector", o_dout, 8'h45);

        // subordinate, identity match (R8)
        is_master = 1'b0; my_id = 3'd3; cas_in = 3'd3; vec_base = 5'h10;
        req_valid = 1'b1; req_level = 3'd6;
        run_ack();
        check("R8 match commits", o_commit, 1);
        check("R8 match drives", o_den, 1);
        check("R8 match vector", o_dout, 8'h86);
        check("R8 match eoi", o_eoi, 1);
        check("R8 no cas drive", o_cas_oe1, 0);

        // subordinate, identity mismatch (R8)
        cas_in = 3'd1; req_valid = 1'b1; req_level = 3'd6;
        run_ack();
        check("R8 mismatch no commit", o_commit, 0);
        check("R8 mismatch off bus", o_den, 0);
        check("R8 mismatch dout zero", o_dout, 0);
        check("R8 mismatch no eoi", o_eoi, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule